// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block guards one hart's load-reserved / store-conditional pairs in front of a memory port that other agents may also write. A load-reserved records the aligned word it touched and marks a reservation as held. A later store-conditional is allowed to reach memory only if that reservation is still held for the same word. In the same cycle, the block returns a status value for the destination register: 0 when the store committed and 1 when it was refused.

A snoop input reports writes made by other agents. The hart's own ordinary stores are also seen through the operation input. Either kind of write to the reserved word cancels the reservation. This includes a plain store of zero that releases a lock. The memory array itself is outside the block. The block drives the write enable, address and data that the array consumes.

The decision is combinational within the operation's cycle. Reservation state changes at the following clock edge.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no reservation is held, so a store-conditional issued before any load-reserved drives memWe low and returns status 1.
- R2: A load-reserved (opKind 1) followed by a store-conditional (opKind 2) to the same word, with no intervening write, asserts memWe in the store-conditional's cycle. In that cycle memAddr equals opAddr, memWdata equals opData, and status is 0.
- R3: A failed store-conditional returns status 1 with scDone high and memWe low.
- R4: Every store-conditional releases the reservation, whether it passed or failed, so an immediately repeated store-conditional fails.
- R5: A snooped write (snoopValid high) to any byte of the reserved word cancels the reservation.
- R6: A snooped write to a different word leaves the reservation intact.
- R7: A store-conditional whose word address differs from the reserved word fails.
- R8: Reservation granularity is one aligned word. Address bits [1:0] are ignored in every comparison.
- R9: A snooped write to the store-conditional's own word in the same cycle makes that store-conditional fail.
- R10: An ordinary store (opKind 3) asserts memWe with scDone low. It cancels the reservation if it hits the reserved word, including a store of zero.
- R11: A new load-reserved replaces any earlier reservation address.
- R12: A load-reserved whose word is hit by a snooped write in the same cycle establishes no reservation.
- R13: scDone is high only in store-conditional cycles. opKind 0 is idle and never writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opKind | input | 2 | 0 idle, 1 load-reserved, 2 store-conditional, 3 ordinary store |
| opAddr | input | ADDR_W | Byte address of the operation |
| opData | input | DATA_W | Store data (rs2 value) |
| snoopValid | input | 1 | Another agent writes memory this cycle |
| snoopAddr | input | ADDR_W | Byte address of the snooped write |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory write address |
| memWdata | output | DATA_W | Memory write data |
| scDone | output | 1 | Status result valid (store-conditional cycle) |
| scStatus | output | DATA_W | 0 on commit, 1 on refusal |

## Verification
On every cycle, the embedded properties check the following:
- a captured load-reserved really holds the reservation;
- any release strobe leaves the reservation empty;
- a same-cycle conflicting snoop or a word mismatch never lets a store-conditional write;
- a refusal always carries code 1;
- an ordinary store always writes.

Only the bench's scenarios can show history-dependent outcomes. Examples are whether a snoop several cycles earlier, a replaced reservation, or a repeated store-conditional changes the verdict. The bench covers these with exhaustive sweeps over every pair of byte addresses in a 64-byte space.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LR   = 2'd1,
    OP_SC   = 2'd2,
    OP_ST   = 2'd3
  } opKind_e;

  typedef struct packed {
    logic capture;
    logic drop;
    logic commit;
  } resvStrobe_t;
endpackage

// File: rtl/lrsc_dpath.sv
module lrsc_dpath
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resvStrobe_t       strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              opHitsResv,
  output logic              snoopHitsResv,
  output logic              snoopHitsOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int WORD_W   = ADDR_W - BYTE_LSB;

  logic              resvValid;
  logic [WORD_W-1:0] resvWord;
  logic [WORD_W-1:0] opWord;
  logic [WORD_W-1:0] snoopWord;
  logic              unusedLowBits;

  assign opWord        = opAddr[ADDR_W-1:BYTE_LSB];
  assign snoopWord     = snoopAddr[ADDR_W-1:BYTE_LSB];
  assign unusedLowBits = ^snoopAddr[BYTE_LSB-1:0];

  assign opHitsResv    = resvValid && (opWord == resvWord);
  assign snoopHitsResv = resvValid && snoopValid && (snoopWord == resvWord);
  assign snoopHitsOp   = snoopValid && (snoopWord == opWord);

  assign memAddr  = opAddr;
  assign memWdata = opData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resvValid <= 1'b0;
      resvWord  <= '0;
    end else if (strobe.capture) begin
      resvValid <= 1'b1;
      resvWord  <= opWord;
    end else if (strobe.drop) begin
      resvValid <= 1'b0;
    end
  end

  // R11
  capture_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> opHitsResv || (resvWord == $past(opWord)));

  // R4
  drop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.drop && !strobe.capture) |=> !opHitsResv && !snoopHitsResv);
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opKind_e           opKind,
  input  logic              opHitsResv,
  input  logic              snoopHitsResv,
  input  logic              snoopHitsOp,
  output resvStrobe_t       strobe,
  output logic              memWe,
  output logic              scDone,
  output logic [DATA_W-1:0] scStatus
);
  localparam logic [DATA_W-1:0] FAIL_CODE = DATA_W'(1);

  logic isLr, isSc, isSt, scPass;

  assign isLr   = (opKind == OP_LR);
  assign isSc   = (opKind == OP_SC);
  assign isSt   = (opKind == OP_ST);
  assign scPass = isSc && opHitsResv && !snoopHitsOp;

  always_comb begin
    strobe         = '0;
    strobe.capture = isLr && !snoopHitsOp;
    strobe.drop    = isSc || (isSt && opHitsResv) || snoopHitsResv
                     || (isLr && snoopHitsOp);
    strobe.commit  = scPass;
  end

  assign memWe    = strobe.commit || isSt;
  assign scDone   = isSc;
  assign scStatus = (isSc && !scPass) ? FAIL_CODE : '0;

  // R9
  sc_snoop_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opKind == OP_SC && snoopHitsOp) |-> !memWe && scStatus == FAIL_CODE);

  // R7
  sc_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opKind == OP_SC && !opHitsResv) |-> !memWe);

  // R3
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scDone && !memWe) |-> scStatus == FAIL_CODE);

  // R10
  plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opKind == OP_ST) |-> memWe && !scDone);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opKind == OP_IDLE) |-> !memWe && !scDone);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              scDone,
  output logic [DATA_W-1:0] scStatus
);
  resvStrobe_t strobe;
  logic        opHitsResv, snoopHitsResv, snoopHitsOp;

  lrsc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .opKind       (opKind_e'(opKind)),
    .opHitsResv   (opHitsResv),
    .snoopHitsResv(snoopHitsResv),
    .snoopHitsOp  (snoopHitsOp),
    .strobe       (strobe),
    .memWe        (memWe),
    .scDone       (scDone),
    .scStatus     (scStatus)
  );

  lrsc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .opAddr       (opAddr),
    .opData       (opData),
    .snoopValid   (snoopValid),
    .snoopAddr    (snoopAddr),
    .opHitsResv   (opHitsResv),
    .snoopHitsResv(snoopHitsResv),
    .snoopHitsOp  (snoopHitsOp),
    .memAddr      (memAddr),
    .memWdata     (memWdata)
  );
endmodule

// File: tb/lrsc_monitor_test.sv
`timescale 1ns/1ps
module lrsc_monitor_test;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    opKind = 2'd0;
  logic [AW-1:0] opAddr = '0;
  logic [DW-1:0] opData = '0;
  logic          snoopValid = 1'b0;
  logic [AW-1:0] snoopAddr = '0;
  logic          memWe, scDone;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, scStatus;

  logic          oWe, oDone;
  logic [AW-1:0] oAddr;
  logic [DW-1:0] oData, oStat;

  int nCmp = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .opKind(opKind), .opAddr(opAddr),
    .opData(opData), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .scDone(scDone), .scStatus(scStatus)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic sv, input logic [AW-1:0] sa);
    @(negedge clk);
    opKind = k; opAddr = a; opData = d; snoopValid = sv; snoopAddr = sa;
    #1;
    oWe = memWe; oAddr = memAddr; oData = memWdata; oDone = scDone; oStat = scStatus;
  endtask

  task automatic expectSc(input string req, input logic pass);
    check(req, {31'd0, oDone}, 32'd1);
    check(req, {31'd0, oWe}, {31'd0, pass});
    check(req, oStat, pass ? 32'd0 : 32'd1);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R13 idle during and after reset
    doOp(2'd0, '0, '0, 1'b0, '0);
    check("R13", {31'd0, oWe}, 32'd0);
    check("R13", {31'd0, oDone}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1 store-conditional with no reservation
    doOp(2'd2, 6'd8, 32'h55, 1'b0, '0);
    expectSc("R1", 1'b0);

    // R2 R7 R8 R4 exhaustive address pairs
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        logic pass;
        logic [DW-1:0] d;
        pass = ((a >> 2) == (b >> 2));
        d = 32'hA000_0000 + (a * 64 + b);
        doOp(2'd1, AW'(a), '0, 1'b0, '0);
        check("R13", {31'd0, oDone}, 32'd0);
        doOp(2'd2, AW'(b), d, 1'b0, '0);
        expectSc(pass ? "R2_R8" : "R7", pass);
        if (pass) begin
          check("R2", {26'd0, oAddr}, b);
          check("R2", oData, d);
        end
        doOp(2'd2, AW'(b), d, 1'b0, '0);
        expectSc("R4", 1'b0);
      end
    end

    // R5 R6 snoop in an intermediate cycle
    for (int a = 0; a < 64; a++) begin
      for (int s = 0; s < 64; s++) begin
        logic pass;
        pass = ((a >> 2) != (s >> 2));
        doOp(2'd1, AW'(a), '0, 1'b0, '0);
        doOp(2'd0, '0, '0, 1'b1, AW'(s));
        check("R13", {31'd0, oWe}, 32'd0);
        doOp(2'd2, AW'(a), 32'h1234, 1'b0, '0);
        expectSc(pass ? "R6" : "R5", pass);
      end
    end

    // R9 same-cycle snoop on the store-conditional word
    doOp(2'd1, 6'd20, '0, 1'b0, '0);
    doOp(2'd2, 6'd20, 32'h7, 1'b1, 6'd23);
    expectSc("R9", 1'b0);
    doOp(2'd1, 6'd20, '0, 1'b0, '0);
    doOp(2'd2, 6'd20, 32'h7, 1'b1, 6'd24);
    expectSc("R9", 1'b1);

    // R10 ordinary store, lock release with zero
    doOp(2'd1, 6'd8, '0, 1'b0, '0);
    doOp(2'd3, 6'd9, 32'd0, 1'b0, '0);
    check("R10", {31'd0, oWe}, 32'd1);
    check("R10", {31'd0, oDone}, 32'd0);
    check("R10", oData, 32'd0);
    doOp(2'd2, 6'd8, 32'h1, 1'b0, '0);
    expectSc("R10", 1'b0);
    doOp(2'd1, 6'd8, '0, 1'b0, '0);
    doOp(2'd3, 6'd40, 32'h9, 1'b0, '0);
    check("R10", {31'd0, oWe}, 32'd1);
    doOp(2'd2, 6'd8, 32'h1, 1'b0, '0);
    expectSc("R10", 1'b1);

    // R11 newer load-reserved replaces the address
    doOp(2'd1, 6'd4, '0, 1'b0, '0);
    doOp(2'd1, 6'd20, '0, 1'b0, '0);
    doOp(2'd2, 6'd4, 32'h2, 1'b0, '0);
    expectSc("R11", 1'b0);
    doOp(2'd1, 6'd4, '0, 1'b0, '0);
    doOp(2'd1, 6'd20, '0, 1'b0, '0);
    doOp(2'd2, 6'd20, 32'h2, 1'b0, '0);
    expectSc("R11", 1'b1);

    // R12 load-reserved with a same-cycle snoop
    doOp(2'd1, 6'd12, '0, 1'b1, 6'd13);
    doOp(2'd2, 6'd12, 32'h3, 1'b0, '0);
    expectSc("R12", 1'b0);
    doOp(2'd1, 6'd12, '0, 1'b1, 6'd40);
    doOp(2'd2, 6'd12, 32'h3, 1'b0, '0);
    expectSc("R12", 1'b1);

    doOp(2'd0, '0, '0, 1'b0, '0);
    finishRun();
  end
endmodule